// File: doc/BRIEF.md
# Debug Register Readout SPI Slave

This block gives an external debug controller read access to a CPU's internal state over a four-wire serial link. The controller owns the serial clock and the active-low chip select, so the CPU side is the target. After the controller pulls chip select low, it sends a short selector code. The block then returns one 16-bit word from the CPU.

There are four sources: the accumulator, the address register, the program counter, and the main sequencer state. The sequencer state is zero-extended to the word width. The link runs in SPI mode 0.

The serial clock, chip select and data input come from outside the system clock domain. Each one passes through a flop synchronizer, and both clock edges are detected after synchronization. The chosen value is captured once, when the selector is complete, so the word that goes out is one consistent snapshot. The link is normally used while the CPU is held by its external halt input.

Top module: `dbgPeekSlave`

## Requirements
- R1: After reset, `misoOut` and `misoEn` are both 0.
- R2: After chip select falls, the selector is taken from `mosiIn` on the first two rising serial-clock edges, MSB first. Code 2'b00 selects `accD`, 2'b01 selects `addrA`, 2'b10 selects `progCnt`, and 2'b11 selects `fsmState`.
- R3: The selected word goes out on `misoOut` MSB first. One new bit is presented after each of the 16 falling serial-clock edges that follow the second selector rising edge, so the controller can sample it on the next rising edge.
- R4: Selector 2'b11 returns `fsmState` zero-extended to the word width.
- R5: The word is captured when the selector completes. Changing the source input during the stream has no effect on the bits sent.
- R6: After the 16th data bit, every further falling edge drives `misoOut` to 0.
- R7: Raising chip select at any point clears `misoOut` and `misoEn`. The next transfer starts again from a new selector.
- R8: `misoEn` is 1 while the synchronized chip select is low.
- R9: `misoOut` stays 0 while the selector bits are being received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclkIn | input | 1 | Serial clock from the debug controller |
| csnIn | input | 1 | Active-low chip select from the debug controller |
| mosiIn | input | 1 | Serial data in (selector bits) |
| accD | input | DATA_W | Accumulator value |
| addrA | input | DATA_W | Address register value |
| progCnt | input | DATA_W | Program counter value |
| fsmState | input | STATE_W | Main sequencer state |
| misoOut | output | 1 | Serial data out |
| misoEn | output | 1 | Output enable for the serial data pin |

## Verification
The bench builds the block with a 16-bit word, a 3-bit sequencer state and two synchronizer stages. With these values the zero-extension of a narrower state field can be checked, and the full three-cycle path from a pin change to an output change is exercised.

The serial half-period is eight system clocks. This spacing lets the latency of each edge settle before the controller samples, and it separates falling edges ignored during the selector phase from falling edges that shift data out.

// File: rtl/dbgPeekPkg.sv
package dbgPeekPkg;
  localparam int SEL_W = 2;

  typedef struct packed {
    logic active;   // synchronized chip select is low
    logic clr;      // drop everything, chip select is high
    logic selShift; // take one selector bit
    logic load;     // capture chosen word
    logic outShift; // present next output bit
  } peekStrb_t;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SEL   = 2'd1,
    PH_LOAD  = 2'd2,
    PH_SHIFT = 2'd3
  } peekPhase_t;
endpackage

// File: rtl/dbgPeekCtrl.sv
module dbgPeekCtrl
  import dbgPeekPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclkIn,
  input  logic      csnIn,
  input  logic      mosiIn,
  output logic      mosiBit,
  output peekStrb_t strb
);
  localparam int CNT_W = $clog2(SEL_W + 1);

  logic [SYNC_STAGES-1:0] sclkPipe, csnPipe, mosiPipe;
  logic sclkPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclkPipe <= '0;
      csnPipe  <= '1;
      mosiPipe <= '0;
      sclkPrev <= 1'b0;
    end else begin
      sclkPipe <= {sclkPipe[SYNC_STAGES-2:0], sclkIn};
      csnPipe  <= {csnPipe[SYNC_STAGES-2:0], csnIn};
      mosiPipe <= {mosiPipe[SYNC_STAGES-2:0], mosiIn};
      sclkPrev <= sclkPipe[SYNC_STAGES-1];
    end
  end

  logic sclkS, active, sclkRise, sclkFall;
  assign sclkS    = sclkPipe[SYNC_STAGES-1];
  assign active   = ~csnPipe[SYNC_STAGES-1];
  assign sclkRise = sclkS & ~sclkPrev;
  assign sclkFall = ~sclkS & sclkPrev;
  assign mosiBit  = mosiPipe[SYNC_STAGES-1];

  peekPhase_t phase, phaseNext;
  logic [CNT_W-1:0] selCnt, selCntNext;

  always_comb begin
    phaseNext  = phase;
    selCntNext = selCnt;
    strb       = '0;
    strb.active = active;
    if (!active) begin
      strb.clr   = 1'b1;
      phaseNext  = PH_IDLE;
      selCntNext = '0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          phaseNext  = PH_SEL;
          selCntNext = '0;
        end
        PH_SEL: if (sclkRise) begin
          strb.selShift = 1'b1;
          selCntNext    = selCnt + 1'b1;
          if (selCnt == CNT_W'(SEL_W - 1)) phaseNext = PH_LOAD;
        end
        PH_LOAD: begin
          strb.load = 1'b1;
          phaseNext = PH_SHIFT;
        end
        PH_SHIFT: if (sclkFall) strb.outShift = 1'b1;
        default: phaseNext = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase  <= PH_IDLE;
      selCnt <= '0;
    end else begin
      phase  <= phaseNext;
      selCnt <= selCntNext;
    end
  end

  // R2
  load_after_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |-> (selCnt == CNT_W'(SEL_W) && phase == PH_LOAD));

  // R3
  shift_needs_cs_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.outShift |-> (active && $past(strb.load || phase == PH_SHIFT)));

  // R7
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.clr, strb.selShift, strb.load, strb.outShift}));
endmodule

// File: rtl/dbgPeekData.sv
module dbgPeekData
  import dbgPeekPkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int STATE_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  peekStrb_t          strb,
  input  logic               mosiBit,
  input  logic [DATA_W-1:0]  accD,
  input  logic [DATA_W-1:0]  addrA,
  input  logic [DATA_W-1:0]  progCnt,
  input  logic [STATE_W-1:0] fsmState,
  output logic               misoOut,
  output logic               misoEn
);
  logic [SEL_W-1:0]  selReg;
  logic [DATA_W-1:0] shiftReg, chosen;

  always_comb begin
    unique case (selReg)
      2'd0:    chosen = accD;
      2'd1:    chosen = addrA;
      2'd2:    chosen = progCnt;
      default: chosen = DATA_W'(fsmState);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.clr) begin
      selReg   <= '0;
      shiftReg <= '0;
      misoOut  <= 1'b0;
    end else begin
      if (strb.selShift) selReg <= {selReg[SEL_W-2:0], mosiBit};
      if (strb.load)     shiftReg <= chosen;
      if (strb.outShift) begin
        misoOut  <= shiftReg[DATA_W-1];
        shiftReg <= {shiftReg[DATA_W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) misoEn <= 1'b0;
    else       misoEn <= strb.active;
  end

  // R7
  abort_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.active |=> (!misoOut && !misoEn));

  // R9
  quiet_select_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.selShift |=> !misoOut);

  // R8
  en_follows_cs_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.active |=> misoEn);
endmodule

// File: rtl/dbgPeekSlave.sv
module dbgPeekSlave
  import dbgPeekPkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int STATE_W     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclkIn,
  input  logic               csnIn,
  input  logic               mosiIn,
  input  logic [DATA_W-1:0]  accD,
  input  logic [DATA_W-1:0]  addrA,
  input  logic [DATA_W-1:0]  progCnt,
  input  logic [STATE_W-1:0] fsmState,
  output logic               misoOut,
  output logic               misoEn
);
  peekStrb_t strb;
  logic      mosiBit;

  dbgPeekCtrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .csnIn(csnIn), .mosiIn(mosiIn),
    .mosiBit(mosiBit), .strb(strb)
  );

  dbgPeekData #(.DATA_W(DATA_W), .STATE_W(STATE_W)) data_i (
    .clk(clk), .rstN(rstN), .strb(strb), .mosiBit(mosiBit),
    .accD(accD), .addrA(addrA), .progCnt(progCnt), .fsmState(fsmState),
    .misoOut(misoOut), .misoEn(misoEn)
  );
endmodule

// File: tb/dbgPeekSlave_tb_top.sv
`timescale 1ns/1ps
module dbgPeekSlave_tb_top;
  localparam int DATA_W = 16;
  localparam int STATE_W = 3;
  localparam int HALF = 40;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclkIn = 1'b0, csnIn = 1'b1, mosiIn = 1'b0;
  logic [DATA_W-1:0] accD = 16'hA5C3, addrA = 16'h1E0F, progCnt = 16'h8001;
  logic [STATE_W-1:0] fsmState = 3'b101;
  logic misoOut, misoEn;

  always #2.5 clk = ~clk;

  dbgPeekSlave #(.DATA_W(DATA_W), .STATE_W(STATE_W), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .csnIn(csnIn), .mosiIn(mosiIn),
    .accD(accD), .addrA(addrA), .progCnt(progCnt), .fsmState(fsmState),
    .misoOut(misoOut), .misoEn(misoEn)
  );

  int nRun = 0, nFail = 0;
  bit finished = 0;
  logic [DATA_W-1:0] expQ[$], gotQ[$];
  string tagQ[$];

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    nRun++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic spiBit(input logic mo, output logic mi);
    mosiIn = mo;
    #(HALF);
    mi = misoOut;
    sclkIn = 1'b1;
    #(HALF);
    sclkIn = 1'b0;
  endtask

  // driver: one transfer, expected word pushed to the scoreboard
  task automatic xfer(input logic [1:0] sel, input logic [DATA_W-1:0] exp,
                      input string tag, input bit mutate);
    logic mi;
    logic [DATA_W-1:0] word = '0;
    csnIn = 1'b0;
    #(HALF);
    for (int i = 1; i >= 0; i--) begin
      spiBit(sel[i], mi);
      check("R9 miso quiet during selector", {31'b0, mi}, 32'd0);
    end
    expQ.push_back(exp);
    tagQ.push_back(tag);
    for (int i = 0; i < DATA_W; i++) begin
      spiBit(1'b0, mi);
      word = {word[DATA_W-2:0], mi};
      if (i == 0) check("R8 misoEn while selected", {31'b0, misoEn}, 32'd1);
      if (mutate && i == 4) accD = ~accD;
    end
    gotQ.push_back(word);
    for (int i = 0; i < 2; i++) begin
      spiBit(1'b0, mi);
      check("R6 zero after last bit", {31'b0, mi}, 32'd0);
    end
    #(HALF);
    csnIn = 1'b1;
    #(4 * HALF);
    check("R7 misoEn cleared by CSB", {31'b0, misoEn}, 32'd0);
  endtask

  // monitor: compares each streamed word against the scoreboard
  initial begin
    forever begin
      wait (gotQ.size() > 0);
      check(tagQ.pop_front(), {16'b0, gotQ.pop_front()}, {16'b0, expQ.pop_front()});
    end
  end

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  endtask

  initial begin
    #(100000 * 5);
    nRun++; nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish();
  end

  initial begin
    logic mi;
    repeat (5) @(negedge clk);
    check("R1 reset miso", {31'b0, misoOut}, 32'd0);
    check("R1 reset misoEn", {31'b0, misoEn}, 32'd0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 idle after reset", {30'b0, misoEn, misoOut}, 32'd0);

    xfer(2'b00, 16'hA5C3, "R2 R3 sel 00 accumulator", 0);
    xfer(2'b01, 16'h1E0F, "R2 R3 sel 01 address", 0);
    xfer(2'b10, 16'h8001, "R2 R3 sel 10 program counter", 0);
    xfer(2'b11, 16'h0005, "R4 sel 11 state zero-extended", 0);
    fsmState = 3'b111;
    xfer(2'b11, 16'h0007, "R4 state all ones", 0);
    accD = 16'h3C96;
    xfer(2'b00, 16'h3C96, "R5 capture ignores later change", 1);
    check("R5 source was changed", {16'b0, accD}, {16'b0, 16'hC369});

    // R7: abort mid-stream, then a clean transfer
    csnIn = 1'b0;
    #(HALF);
    spiBit(1'b1, mi);
    spiBit(1'b0, mi);
    for (int i = 0; i < 5; i++) spiBit(1'b0, mi);
    check("R7 stream started before abort", {31'b0, misoEn}, 32'd1);
    csnIn = 1'b1;
    #(4 * HALF);
    check("R7 abort clears miso", {31'b0, misoOut}, 32'd0);
    check("R7 abort clears misoEn", {31'b0, misoEn}, 32'd0);
    xfer(2'b01, 16'h1E0F, "R7 fresh transfer after abort", 0);

    #(4 * HALF);
    check("R6 scoreboard drained", expQ.size(), 32'd0);
    finish();
  end
endmodule